// File: doc/BRIEF.md
# Time-Aware Egress Gate Scheduler

This block opens and closes the per-class transmission gates of every egress port of a switch according to a time-triggered schedule. A single shared table of schedule entries holds, for each entry, a gate word with one bit per traffic class and a hold time counted in deltas. A second, per-port table gives each port a slice of that shared table (first and last index) and an entry-point delta. The entry-point delta is the number of deltas after the common operational start time at which the port begins its slice.

The engine is armed by a start command and stays idle until an externally maintained PTP time counter reaches the programmed start time. From then on it counts only scheduler ticks, one per clock. A delta is nominally 25 ticks long. Each port walks its slice entry by entry and wraps back to the slice's first entry after the last one.

The PTP time domain defines a correction period. Each time the period elapses, the drift measured by an external servo is added to a pending correction. That correction is then paid out over the following deltas by making each one a few ticks longer or shorter than nominal. A stop command returns the engine to idle and opens every gate. The tables are loaded through plain write ports.

Top module: `tas_gate_engine`

## Requirements
- R1: After reset all gate bits are 1 (open), `started_o` is 0 and `stopped_o` is 0.
- R2: A `start_cmd` pulse while idle arms the engine and clears `stopped_o`. The engine enters the running state on the first clock edge where `ptp_time >= start_time`, and `started_o` is 1 from the following cycle.
- R3: In the running state one delta lasts `TICKS_NOM` (25) clock cycles while no correction is pending.
- R4: A port with entry-point delta N (N >= 1) keeps all gates open until the end of the Nth delta after entering the running state, then starts its slice at its first index. A port with entry-point delta 0 never starts and keeps all gates open.
- R5: An active port holds each entry for the entry's hold time in deltas (0 is treated as 1), then moves to the next index. After its last index it wraps to its first index.
- R6: Bit i of `gate_o[p]` is the open (1) or closed (0) state of traffic class i on port p. While port p is active it equals the gate word of port p's current entry.
- R7: The first correction boundary is at `start_time + corr_period`, and each later one is `corr_period` after the previous. At each boundary the signed `drift_in` is added to the pending correction.
- R8: At each delta end the next delta's length is 25 plus the pending correction clipped to ±5 ticks, and the clipped amount is removed from the pending correction. A positive correction lengthens deltas.
- R9: A `stop_cmd` wins over `start_cmd`. In the cycle after it, every gate bit is 1, `started_o` is 0 and `stopped_o` is 1.
- R10: A `start_cmd` while armed or running has no effect on the state or on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scheduler clock, one tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| ptp_time | input | TIME_W | Current PTP time |
| start_time | input | TIME_W | Operational start time in PTP units |
| corr_period | input | TIME_W | Correction period in PTP units |
| drift_in | input | DRIFT_W | Signed measured drift in ticks |
| start_cmd | input | 1 | Start command pulse |
| stop_cmd | input | 1 | Stop command pulse |
| sch_we | input | 1 | Schedule entry write enable |
| sch_addr | input | log2(NUM_ENTRIES) | Schedule entry index |
| sch_mask | input | 8 | Gate word to write |
| sch_dur | input | 8 | Hold time in deltas to write |
| ep_we | input | 1 | Entry-point write enable |
| ep_port | input | log2(NUM_PORTS) | Port selected for the entry-point write |
| ep_start | input | log2(NUM_ENTRIES) | First index of the port's slice |
| ep_end | input | log2(NUM_ENTRIES) | Last index of the port's slice |
| ep_delta | input | EP_W | Entry-point delta of the port |
| gate_o | output | NUM_PORTS x 8 | Per-port, per-class gate state |
| started_o | output | 1 | Schedule is running |
| stopped_o | output | 1 | Schedule was stopped by command |

## Verification
The hardest state to reach is a delta boundary that coincides with a correction boundary while an earlier correction is still being paid out. Reaching it takes a run long enough to cross several correction periods, with a drift larger than the per-delta limit and a change of sign in the middle. The stimulus does this with a correction period that is not a multiple of the delta length, so boundaries drift across delta ends. Every clock, the port gates and the flags are compared against a behavioural model that tracks ticks, deltas, pending correction and slice positions as plain integers. The run also includes a stop issued together with a start, a restart with a new start time, and ports with staggered and zero entry points.

// File: rtl/tas_pkg.sv
package tas_pkg;

    localparam int TC_N   = 8;
    localparam int DUR_W  = 8;
    localparam int PEND_W = 16;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_ARMED = 2'd1,
        ENG_RUN   = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic [TC_N-1:0]  mask;
        logic [DUR_W-1:0] dur;
    } sched_ent_t;

    // limit a pending correction to +/- lim ticks for one delta
    function automatic logic signed [PEND_W-1:0] clamp_step(
        input logic signed [PEND_W-1:0] p,
        input int lim
    );
        logic signed [PEND_W-1:0] l;
        l = PEND_W'(lim);
        if (p > l)       return l;
        else if (p < -l) return -l;
        else             return p;
    endfunction

endpackage

// File: rtl/tas_delta_gen.sv
module tas_delta_gen
    import tas_pkg::*;
#(
    parameter int TIME_W    = 32,
    parameter int TICKS_NOM = 25,
    parameter int MAX_ADJ   = 5,
    parameter int DRIFT_W   = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      run_en,
    input  logic                      run_start,
    input  logic [TIME_W-1:0]         ptp_time,
    input  logic [TIME_W-1:0]         corr_base,
    input  logic [TIME_W-1:0]         corr_period,
    input  logic signed [DRIFT_W-1:0] drift_in,
    output logic                      delta_end
);

    localparam int LEN_W = $clog2(TICKS_NOM + MAX_ADJ + 1);

    logic [LEN_W-1:0]         tick_q, len_q;
    logic signed [PEND_W-1:0] pend_q, pend_d, adj, drift_ext;
    logic [TIME_W-1:0]        next_corr_q;
    logic                     corr_hit;

    always_comb begin
        delta_end = run_en && (tick_q == len_q - LEN_W'(1));
        adj       = clamp_step(pend_q, MAX_ADJ);
        corr_hit  = run_en && (ptp_time >= next_corr_q);
        drift_ext = {{(PEND_W-DRIFT_W){drift_in[DRIFT_W-1]}}, drift_in};
        pend_d    = pend_q;
        if (delta_end) pend_d = pend_d - adj;
        if (corr_hit)  pend_d = pend_d + drift_ext;
    end

    always_ff @(posedge clk) begin
        if (rst || (!run_en && !run_start)) begin
            tick_q      <= '0;
            len_q       <= LEN_W'(TICKS_NOM);
            pend_q      <= '0;
            next_corr_q <= '0;
        end else if (run_start) begin
            tick_q      <= '0;
            len_q       <= LEN_W'(TICKS_NOM);
            pend_q      <= '0;
            next_corr_q <= corr_base + corr_period;
        end else begin
            if (delta_end) begin
                tick_q <= '0;
                len_q  <= LEN_W'(TICKS_NOM + int'(adj));
            end else begin
                tick_q <= tick_q + LEN_W'(1);
            end
            pend_q <= pend_d;
            if (corr_hit) next_corr_q <= next_corr_q + corr_period;
        end
    end

    // R8
    len_range_chk: assert property (@(posedge clk) disable iff (rst)
        run_en |-> (len_q >= LEN_W'(TICKS_NOM - MAX_ADJ)) &&
                   (len_q <= LEN_W'(TICKS_NOM + MAX_ADJ)));

    // R3
    tick_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run_en |-> (tick_q < len_q));

endmodule

// File: rtl/tas_port_seq.sv
module tas_port_seq
    import tas_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int EP_W  = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             delta_end,
    input  logic [EP_W-1:0]  dcnt_next,
    input  logic [EP_W-1:0]  ep_delta,
    input  logic [IDX_W-1:0] start_idx,
    input  logic [IDX_W-1:0] end_idx,
    input  logic [DUR_W-1:0] dur_start,
    input  logic [DUR_W-1:0] dur_next,
    output logic             active,
    output logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] next_idx
);

    logic             act_q;
    logic [IDX_W-1:0] idx_q;
    logic [DUR_W-1:0] rem_q;

    always_comb begin
        next_idx = (idx_q == end_idx) ? start_idx : idx_q + IDX_W'(1);
        active   = act_q;
        idx      = idx_q;
    end

    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            act_q <= 1'b0;
            idx_q <= '0;
            rem_q <= '0;
        end else if (delta_end) begin
            if (!act_q) begin
                if (ep_delta != '0 && dcnt_next == ep_delta) begin
                    act_q <= 1'b1;
                    idx_q <= start_idx;
                    rem_q <= dur_start;
                end
            end else if (rem_q <= DUR_W'(1)) begin
                idx_q <= next_idx;
                rem_q <= dur_next;
            end else begin
                rem_q <= rem_q - DUR_W'(1);
            end
        end
    end

    // R4
    act_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(act_q) |-> $past(delta_end));

    // R5
    idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (act_q && $past(act_q) && !$past(delta_end)) |-> $stable(idx_q));

endmodule

// File: rtl/tas_gate_engine.sv
module tas_gate_engine
    import tas_pkg::*;
#(
    parameter int NUM_PORTS   = 5,
    parameter int NUM_ENTRIES = 16,
    parameter int EP_W        = 20,
    parameter int TIME_W      = 32,
    parameter int TICKS_NOM   = 25,
    parameter int MAX_ADJ     = 5,
    parameter int DRIFT_W     = 8,
    localparam int IDX_W      = $clog2(NUM_ENTRIES),
    localparam int PORT_W     = $clog2(NUM_PORTS)
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [TIME_W-1:0]                  ptp_time,
    input  logic [TIME_W-1:0]                  start_time,
    input  logic [TIME_W-1:0]                  corr_period,
    input  logic signed [DRIFT_W-1:0]          drift_in,
    input  logic                               start_cmd,
    input  logic                               stop_cmd,
    input  logic                               sch_we,
    input  logic [IDX_W-1:0]                   sch_addr,
    input  logic [TC_N-1:0]                    sch_mask,
    input  logic [DUR_W-1:0]                   sch_dur,
    input  logic                               ep_we,
    input  logic [PORT_W-1:0]                  ep_port,
    input  logic [IDX_W-1:0]                   ep_start,
    input  logic [IDX_W-1:0]                   ep_end,
    input  logic [EP_W-1:0]                    ep_delta,
    output logic [NUM_PORTS-1:0][TC_N-1:0]     gate_o,
    output logic                               started_o,
    output logic                               stopped_o
);

    sched_ent_t       tbl_q      [NUM_ENTRIES];
    logic [IDX_W-1:0] ep_start_q [NUM_PORTS];
    logic [IDX_W-1:0] ep_end_q   [NUM_PORTS];
    logic [EP_W-1:0]  ep_delta_q [NUM_PORTS];

    eng_state_e       st_q;
    logic             stopped_q;
    logic [EP_W-1:0]  dcnt_q, dcnt_next;
    logic             run_en, run_start, delta_end, time_ok;

    logic             act_w  [NUM_PORTS];
    logic [IDX_W-1:0] idx_w  [NUM_PORTS];
    logic [IDX_W-1:0] nidx_w [NUM_PORTS];

    // table write ports
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_ENTRIES; i++) tbl_q[i] <= '0;
            for (int i = 0; i < NUM_PORTS; i++) begin
                ep_start_q[i] <= '0;
                ep_end_q[i]   <= '0;
                ep_delta_q[i] <= '0;
            end
        end else begin
            if (sch_we) begin
                tbl_q[sch_addr].mask <= sch_mask;
                tbl_q[sch_addr].dur  <= sch_dur;
            end
            if (ep_we && (int'(ep_port) < NUM_PORTS)) begin
                ep_start_q[ep_port] <= ep_start;
                ep_end_q[ep_port]   <= ep_end;
                ep_delta_q[ep_port] <= ep_delta;
            end
        end
    end

    // control
    always_comb begin
        time_ok   = (ptp_time >= start_time);
        run_en    = (st_q == ENG_RUN) && !stop_cmd;
        run_start = (st_q == ENG_ARMED) && time_ok && !stop_cmd;
        dcnt_next = (dcnt_q == '1) ? dcnt_q : dcnt_q + EP_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ENG_IDLE;
            stopped_q <= 1'b0;
        end else if (stop_cmd) begin
            st_q      <= ENG_IDLE;
            stopped_q <= 1'b1;
        end else begin
            unique case (st_q)
                ENG_IDLE: if (start_cmd) begin
                    st_q      <= ENG_ARMED;
                    stopped_q <= 1'b0;
                end
                ENG_ARMED: if (time_ok) st_q <= ENG_RUN;
                default: st_q <= st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run_en) dcnt_q <= '0;
        else if (delta_end) dcnt_q <= dcnt_next;
    end

    tas_delta_gen #(
        .TIME_W   (TIME_W),
        .TICKS_NOM(TICKS_NOM),
        .MAX_ADJ  (MAX_ADJ),
        .DRIFT_W  (DRIFT_W)
    ) u_dgen (
        .clk        (clk),
        .rst        (rst),
        .run_en     (run_en),
        .run_start  (run_start),
        .ptp_time   (ptp_time),
        .corr_base  (start_time),
        .corr_period(corr_period),
        .drift_in   (drift_in),
        .delta_end  (delta_end)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        tas_port_seq #(
            .IDX_W(IDX_W),
            .EP_W (EP_W)
        ) u_seq (
            .clk      (clk),
            .rst      (rst),
            .run_en   (run_en),
            .delta_end(delta_end),
            .dcnt_next(dcnt_next),
            .ep_delta (ep_delta_q[p]),
            .start_idx(ep_start_q[p]),
            .end_idx  (ep_end_q[p]),
            .dur_start(tbl_q[ep_start_q[p]].dur),
            .dur_next (tbl_q[nidx_w[p]].dur),
            .active   (act_w[p]),
            .idx      (idx_w[p]),
            .next_idx (nidx_w[p])
        );

        always_comb gate_o[p] = act_w[p] ? tbl_q[idx_w[p]].mask : '1;
    end

    assign started_o = (st_q == ENG_RUN);
    assign stopped_o = stopped_q;

    // R9
    stop_open_chk: assert property (@(posedge clk) disable iff (rst)
        stop_cmd |=> (gate_o == '1) && !started_o && stopped_o);

    // R2
    start_time_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(started_o) |-> $past(ptp_time >= start_time));

    // R10
    run_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (started_o && !stop_cmd) |=> started_o);

endmodule

// File: tb/sim_tas_gate_engine.sv
module sim_tas_gate_engine;
    import tas_pkg::*;

    localparam int NP  = 5;
    localparam int NE  = 16;
    localparam int EPW = 20;

    logic              clk = 1'b0;
    logic              rst;
    logic [31:0]       ptp_time;
    logic [31:0]       start_time;
    logic [31:0]       corr_period;
    logic signed [7:0] drift_in;
    logic              start_cmd, stop_cmd;
    logic              sch_we;
    logic [3:0]        sch_addr;
    logic [7:0]        sch_mask, sch_dur;
    logic              ep_we;
    logic [2:0]        ep_port;
    logic [3:0]        ep_start, ep_end;
    logic [EPW-1:0]    ep_delta;
    logic [NP-1:0][7:0] gate_o;
    logic              started_o, stopped_o;

    always #4 clk = ~clk;

    tas_gate_engine u0 (
        .clk(clk), .rst(rst), .ptp_time(ptp_time), .start_time(start_time),
        .corr_period(corr_period), .drift_in(drift_in),
        .start_cmd(start_cmd), .stop_cmd(stop_cmd),
        .sch_we(sch_we), .sch_addr(sch_addr), .sch_mask(sch_mask), .sch_dur(sch_dur),
        .ep_we(ep_we), .ep_port(ep_port), .ep_start(ep_start), .ep_end(ep_end),
        .ep_delta(ep_delta), .gate_o(gate_o), .started_o(started_o), .stopped_o(stopped_o)
    );

    int checks = 0;
    int bad = 0;
    bit chk_on = 0;

    // reference model state
    int m_mask [NE];
    int m_dur  [NE];
    int m_eps  [NP];
    int m_epe  [NP];
    int m_epd  [NP];
    int m_act  [NP];
    int m_idx  [NP];
    int m_rem  [NP];
    int m_st, m_tick, m_len, m_pend, m_dcnt, m_stopped;
    longint m_nextc;
    int m_adj, m_np;
    bit m_dend, m_hit;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst) ptp_time <= 32'd0;
        else     ptp_time <= ptp_time + 32'd8;
    end

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_stopped = 0; m_tick = 0; m_len = 25; m_pend = 0; m_dcnt = 0;
            for (int p = 0; p < NP; p++) begin m_act[p] = 0; m_idx[p] = 0; m_rem[p] = 0; end
        end else if (stop_cmd) begin
            m_st = 0; m_stopped = 1;
            for (int p = 0; p < NP; p++) m_act[p] = 0;
        end else if (m_st == 0) begin
            if (start_cmd) begin m_st = 1; m_stopped = 0; end
        end else if (m_st == 1) begin
            if (ptp_time >= start_time) begin
                m_st = 2; m_tick = 0; m_dcnt = 0; m_len = 25; m_pend = 0;
                m_nextc = longint'(start_time) + longint'(corr_period);
            end
        end else begin
            m_dend = (m_tick == m_len - 1);
            m_hit  = (longint'(ptp_time) >= m_nextc);
            m_np   = m_pend;
            if (m_dend) begin
                m_adj = (m_pend > 5) ? 5 : ((m_pend < -5) ? -5 : m_pend);
                m_tick = 0;
                m_dcnt = m_dcnt + 1;
                m_len = 25 + m_adj;
                m_np = m_np - m_adj;
                for (int p = 0; p < NP; p++) begin
                    if (m_act[p] == 0) begin
                        if (m_epd[p] != 0 && m_dcnt == m_epd[p]) begin
                            m_act[p] = 1; m_idx[p] = m_eps[p]; m_rem[p] = m_dur[m_eps[p]];
                        end
                    end else if (m_rem[p] <= 1) begin
                        m_idx[p] = (m_idx[p] == m_epe[p]) ? m_eps[p] : (m_idx[p] + 1) % NE;
                        m_rem[p] = m_dur[m_idx[p]];
                    end else begin
                        m_rem[p] = m_rem[p] - 1;
                    end
                end
            end else begin
                m_tick = m_tick + 1;
            end
            if (m_hit) begin
                m_np = m_np + int'(drift_in);
                m_nextc = m_nextc + longint'(corr_period);
            end
            m_pend = m_np;
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && chk_on) begin
            for (int p = 0; p < NP; p++) begin
                chk(gate_o[p] == ((m_st == 2 && m_act[p] != 0) ? 8'(m_mask[m_idx[p]]) : 8'hFF),
                    "R3/R4/R5/R6/R7/R8", $sformatf("gate port %0d", p), longint'(gate_o[p]),
                    (m_st == 2 && m_act[p] != 0) ? longint'(m_mask[m_idx[p]]) : 64'hFF);
            end
            chk(started_o == (m_st == 2), "R2/R10", "started_o",
                longint'(started_o), longint'(m_st == 2));
            chk(stopped_o == (m_stopped != 0), "R9", "stopped_o",
                longint'(stopped_o), longint'(m_stopped));
        end
    end

    task automatic wr_ent(input int a, input int mask, input int dur);
        @(negedge clk);
        sch_we = 1; sch_addr = 4'(a); sch_mask = 8'(mask); sch_dur = 8'(dur);
        m_mask[a] = mask; m_dur[a] = dur;
        @(negedge clk);
        sch_we = 0;
    endtask

    task automatic wr_ep(input int p, input int s, input int e, input int d);
        @(negedge clk);
        ep_we = 1; ep_port = 3'(p); ep_start = 4'(s); ep_end = 4'(e); ep_delta = EPW'(d);
        m_eps[p] = s; m_epe[p] = e; m_epd[p] = d;
        @(negedge clk);
        ep_we = 0;
    endtask

    task automatic pulse(input bit st, input bit sp);
        @(negedge clk);
        start_cmd = st; stop_cmd = sp;
        @(negedge clk);
        start_cmd = 0; stop_cmd = 0;
    endtask

    initial begin
        for (int i = 0; i < NE; i++) begin m_mask[i] = 0; m_dur[i] = 0; end
        for (int p = 0; p < NP; p++) begin m_eps[p] = 0; m_epe[p] = 0; m_epd[p] = 0; end
        rst = 1; start_time = 32'd2000; corr_period = 32'd1576; drift_in = 8'sd0;
        start_cmd = 0; stop_cmd = 0; sch_we = 0; sch_addr = 0; sch_mask = 0; sch_dur = 0;
        ep_we = 0; ep_port = 0; ep_start = 0; ep_end = 0; ep_delta = 0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(gate_o == '1, "R1", "gates after reset", longint'(gate_o[0]), 64'hFF);
        chk(!started_o && !stopped_o, "R1", "flags after reset",
            longint'({started_o, stopped_o}), 0);
        chk_on = 1;

        wr_ent(0, 8'h81, 2); wr_ent(1, 8'h3C, 1); wr_ent(2, 8'hF0, 3);
        wr_ent(3, 8'h0F, 1); wr_ent(4, 8'hAA, 2); wr_ent(5, 8'h55, 1);
        wr_ent(6, 8'h12, 4); wr_ent(7, 8'h34, 0);
        wr_ep(0, 0, 2, 1); wr_ep(1, 3, 4, 3); wr_ep(2, 5, 5, 0);
        wr_ep(3, 6, 7, 2); wr_ep(4, 7, 7, 5);

        drift_in = 8'sd12;
        pulse(1, 0);
        repeat (40) @(negedge clk);
        // R2 armed but start time not reached
        chk(!started_o, "R2", "early start", longint'(started_o), 0);
        pulse(1, 0);                      // R10 start while armed
        repeat (300) @(negedge clk);
        chk(started_o, "R2", "running after start time", longint'(started_o), 1);
        repeat (700) @(negedge clk);
        drift_in = -8'sd9;
        repeat (800) @(negedge clk);
        // R4 zero entry point never starts
        chk(gate_o[2] == 8'hFF, "R4", "port with zero entry point", longint'(gate_o[2]), 64'hFF);
        pulse(1, 0);                      // R10 start while running
        chk(started_o, "R10", "start while running", longint'(started_o), 1);

        // R9 stop together with start
        @(negedge clk);
        start_cmd = 1; stop_cmd = 1;
        @(negedge clk);
        start_cmd = 0; stop_cmd = 0;
        chk(gate_o == '1, "R9", "gates after stop", longint'(gate_o[0]), 64'hFF);
        chk(!started_o && stopped_o, "R9", "flags after stop",
            longint'({started_o, stopped_o}), 1);

        start_time = ptp_time + 32'd800;
        corr_period = 32'd1000;
        drift_in = 8'sd3;
        pulse(1, 0);
        repeat (1300) @(negedge clk);
        pulse(0, 1);
        repeat (5) @(negedge clk);

        chk_on = 0;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule